// File: doc/BRIEF.md
# Bank Conflict Pass Scheduler

This block sits in front of a read-only scratchpad made of 32 banks of 32-bit words. It takes one request that covers 32 lanes, each lane with an enable bit and a byte address, and turns it into a short series of passes. In every pass, each bank delivers one word, and the block raises a grant bit for each lane that the pass serves.

Lanes whose addresses fall in different banks go out together in one pass. Lanes that read the very same word also go out together, because that word is broadcast to all of them. Only lanes that hit one bank at different words are spread over several passes. The block reports the worst bank's word count as the conflict degree, and that number is also the number of passes. While a request is being worked off, the block is busy and refuses new requests. A done pulse marks the last pass.

Top module: `bank_conflict_arbiter`

## Requirements
- R1: The word index of a lane is its byte address shifted right by 2. The bank is the word index modulo 32, and the row is the word index divided by 32. Byte addresses inside one word share that word.
- R2: Active lanes that all fall in different banks, or that only share words, are all granted in a single pass. Word strides of 1 and 3 are examples.
- R3: From the cycle after a request is accepted, conflict_degree equals the largest number of distinct words that the active lanes ask for in any one bank. It is 0 when no lane is active. A word stride of 2 gives 2.
- R4: A request with degree n takes exactly n passes. A request with degree 0 still takes one pass, and that pass has an all-zero grant mask.
- R5: In each pass, every bank serves the word of its lowest-numbered lane that has not yet been granted. Every such pending lane that asks for that word is granted in the same pass.
- R6: A lane whose enable bit is 0 is never granted.
- R7: Over the passes of one request, every active lane is granted exactly once.
- R8: A request is accepted at a rising clock edge where req_valid is 1 and busy is 0. busy is 1 from the next cycle through the last pass. Passes occupy consecutive cycles, and each cycle with busy at 1 is one pass.
- R9: A request presented while busy is 1 is ignored. The ongoing grant sequence and conflict_degree are unaffected.
- R10: done is 1 only in the final pass cycle, together with that pass's grant mask. busy falls after that cycle. grant_mask is 0 whenever busy is 0.
- R11: After reset, busy, done, grant_mask and conflict_degree are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_active | input | LANES | Per-lane enable |
| req_addr | input | LANES*ADDR_W | Byte address of each lane; lane i is at bits [i*ADDR_W +: ADDR_W] |
| busy | output | 1 | A pass is being issued this cycle; new requests are refused |
| grant_mask | output | LANES | Lanes served in the current pass |
| done | output | 1 | The current pass is the last one |
| conflict_degree | output | DEG_W | Worst-bank distinct-word count of the accepted request |

## Verification
A wrong pending-lane register shows up in the very next pass. Either a lane is granted twice, or a lane is dropped and the pass sequence ends early or runs too long. That error appears on grant_mask and done within one cycle of going wrong. A fault in the leader selection or the row comparison shows up as a different grant mask in the first pass, and a fault in the degree count shows up as soon as the request is accepted. The scoreboard compares every pass mask, every done flag and the degree against an independent pass model. This covers single-pass, broadcast, 2-way, 4-way and full 32-way patterns, as well as a request refused while busy.

// File: rtl/arb_pkg.sv
// Package: shared default sizes for the bank conflict scheduler.
// Assumes banks are a power of two and words are a power of two bytes.
package arb_pkg;
    localparam int DEF_LANES      = 32;
    localparam int DEF_BANKS      = 32;
    localparam int DEF_ADDR_W     = 16;
    localparam int DEF_WORD_BYTES = 4;
endpackage

// File: rtl/lane_decode.sv
// Module: lane_decode
// Splits each lane's byte address into bank index and row (word within bank).
// Assumes the byte offset bits inside a word are irrelevant to reads.
module lane_decode #(
    parameter int LANES  = 32,
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 2,
    parameter int BANK_W = 5,
    parameter int ROW_W  = ADDR_W - OFF_W - BANK_W
) (
    input  logic [LANES*ADDR_W-1:0]      addr,
    output logic [LANES-1:0][BANK_W-1:0] bank,
    output logic [LANES-1:0][ROW_W-1:0]  row
);
    logic [LANES*OFF_W-1:0] unused_offset_bits;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // slice one lane's address into its fields
        assign bank[i] = addr[i*ADDR_W + OFF_W +: BANK_W];
        assign row[i]  = addr[i*ADDR_W + OFF_W + BANK_W +: ROW_W];
        assign unused_offset_bits[i*OFF_W +: OFF_W] = addr[i*ADDR_W +: OFF_W];
    end
endmodule

// File: rtl/pass_picker.sv
// Module: pass_picker
// For the pending lanes, picks per bank the lowest pending lane as leader and
// grants every pending lane that reads the leader's word (broadcast).
// Assumes pending lanes are already restricted to active ones.
module pass_picker #(
    parameter int LANES  = 32,
    parameter int BANK_W = 5,
    parameter int ROW_W  = 9
) (
    input  logic [LANES-1:0]             pending,
    input  logic [LANES-1:0][BANK_W-1:0] bank,
    input  logic [LANES-1:0][ROW_W-1:0]  row,
    output logic [LANES-1:0]             grant
);
    logic [LANES-1:0] leader;

    // leader: pending lane with no lower pending lane in the same bank
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            leader[i] = pending[i];
            for (int j = 0; j < LANES; j++) begin
                if (j < i && pending[j] && bank[j] == bank[i]) leader[i] = 1'b0;
            end
        end
    end

    // grant: pending lane not blocked by a leader at another row of its bank
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            grant[i] = pending[i];
            for (int j = 0; j < LANES; j++) begin
                if (leader[j] && bank[j] == bank[i] && row[j] != row[i]) grant[i] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/degree_calc.sv
// Module: degree_calc
// Counts distinct words requested per bank by the active lanes and returns
// the maximum over banks. Assumes DEG_W can hold LANES.
module degree_calc #(
    parameter int LANES  = 32,
    parameter int BANKS  = 32,
    parameter int BANK_W = 5,
    parameter int ROW_W  = 9,
    parameter int DEG_W  = 6
) (
    input  logic [LANES-1:0]             active,
    input  logic [LANES-1:0][BANK_W-1:0] bank,
    input  logic [LANES-1:0][ROW_W-1:0]  row,
    output logic [DEG_W-1:0]             degree
);
    logic [LANES-1:0] first_of_word;

    // first_of_word: active lane with no lower active lane at the same word
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            first_of_word[i] = active[i];
            for (int j = 0; j < LANES; j++) begin
                if (j < i && active[j] && bank[j] == bank[i] && row[j] == row[i])
                    first_of_word[i] = 1'b0;
            end
        end
    end

    // degree: maximum per-bank count of distinct words
    always_comb begin
        logic [DEG_W-1:0] cnt;
        degree = '0;
        for (int b = 0; b < BANKS; b++) begin
            cnt = '0;
            for (int i = 0; i < LANES; i++) begin
                if (first_of_word[i] && bank[i] == BANK_W'(b)) cnt = cnt + DEG_W'(1);
            end
            if (cnt > degree) degree = cnt;
        end
    end
endmodule

// File: rtl/bank_conflict_arbiter.sv
// Module: bank_conflict_arbiter (top)
// Accepts a multi-lane read request when idle, then issues one pass per cycle
// until every active lane has been granted. Reports the conflict degree of the
// accepted request. Assumes the bank RAMs follow grant_mask with their own timing.
module bank_conflict_arbiter
    import arb_pkg::*;
#(
    parameter int LANES      = DEF_LANES,
    parameter int BANKS      = DEF_BANKS,
    parameter int ADDR_W     = DEF_ADDR_W,
    parameter int WORD_BYTES = DEF_WORD_BYTES,
    parameter int DEG_W      = $clog2(LANES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [LANES-1:0]        req_active,
    input  logic [LANES*ADDR_W-1:0] req_addr,
    output logic                    busy,
    output logic [LANES-1:0]        grant_mask,
    output logic                    done,
    output logic [DEG_W-1:0]        conflict_degree
);
    localparam int OFF_W  = $clog2(WORD_BYTES);
    localparam int BANK_W = $clog2(BANKS);
    localparam int ROW_W  = ADDR_W - OFF_W - BANK_W;

    logic [LANES*ADDR_W-1:0]      addr_q;
    logic [LANES-1:0]             pending_q;
    logic                         busy_q;
    logic [DEG_W-1:0]             degree_q;
    logic [LANES-1:0][BANK_W-1:0] in_bank, q_bank;
    logic [LANES-1:0][ROW_W-1:0]  in_row, q_row;
    logic [LANES-1:0]             grant;
    logic [LANES-1:0]             remaining;
    logic [DEG_W-1:0]             degree_next;
    logic                         accept;

    lane_decode #(.LANES(LANES), .ADDR_W(ADDR_W), .OFF_W(OFF_W), .BANK_W(BANK_W), .ROW_W(ROW_W))
        u_dec_in (.addr(req_addr), .bank(in_bank), .row(in_row));

    lane_decode #(.LANES(LANES), .ADDR_W(ADDR_W), .OFF_W(OFF_W), .BANK_W(BANK_W), .ROW_W(ROW_W))
        u_dec_q (.addr(addr_q), .bank(q_bank), .row(q_row));

    degree_calc #(.LANES(LANES), .BANKS(BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W), .DEG_W(DEG_W))
        u_deg (.active(req_active), .bank(in_bank), .row(in_row), .degree(degree_next));

    pass_picker #(.LANES(LANES), .BANK_W(BANK_W), .ROW_W(ROW_W))
        u_pick (.pending(pending_q), .bank(q_bank), .row(q_row), .grant(grant));

    // accept only when idle
    assign accept    = req_valid && !busy_q;
    // lanes still owed a word after this pass
    assign remaining = pending_q & ~grant;

    // request capture and pass sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q    <= '0;
            pending_q <= '0;
            busy_q    <= 1'b0;
            degree_q  <= '0;
        end else if (accept) begin
            addr_q    <= req_addr;
            pending_q <= req_active;
            busy_q    <= 1'b1;
            degree_q  <= degree_next;
        end else if (busy_q) begin
            pending_q <= remaining;
            if (remaining == '0) busy_q <= 1'b0;
        end
    end

    // output drive
    assign busy            = busy_q;
    assign grant_mask      = busy_q ? grant : '0;
    assign done            = busy_q && (remaining == '0);
    assign conflict_degree = degree_q;
endmodule

// File: rtl/arb_checker.sv
// Module: arb_checker
// Temporal checks on the scheduler's ports, bound into every instance.
// Assumes the top's port semantics as given in the brief.
module arb_checker #(
    parameter int LANES = 32,
    parameter int DEG_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic [LANES-1:0] grant_mask,
    input logic [DEG_W-1:0] conflict_degree
);
    logic [LANES-1:0] granted_so_far;
    logic [DEG_W:0]   passes_before;

    // track lanes granted and passes issued within the current request
    always_ff @(posedge clk) begin
        if (!rst_n || !busy || done) begin
            granted_so_far <= '0;
            passes_before  <= '0;
        end else begin
            granted_so_far <= granted_so_far | grant_mask;
            passes_before  <= passes_before + 1'b1;
        end
    end

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (grant_mask == '0 && !done));

    p_done_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    p_grant_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ((grant_mask & granted_so_far) == '0));

    p_pass_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((passes_before + 1'b1) ==
                  ((conflict_degree == '0) ? (DEG_W+1)'(1) : {1'b0, conflict_degree})));

    p_degree_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(conflict_degree)));

    p_progress_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && conflict_degree != '0) |-> (grant_mask != '0));
endmodule

bind bank_conflict_arbiter arb_checker #(.LANES(LANES), .DEG_W(DEG_W)) u_arb_checker (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
    .grant_mask(grant_mask), .conflict_degree(conflict_degree)
);

// File: tb/tb_bank_conflict_arbiter.sv
`timescale 1ns/1ps
module tb_bank_conflict_arbiter;
    localparam int LANES  = 32;
    localparam int ADDR_W = 16;
    localparam int DEG_W  = 6;

    typedef struct {
        logic [LANES-1:0] mask;
        bit               last;
        int               deg;
        logic [LANES-1:0] act;
    } exp_t;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    req_valid = 1'b0;
    logic [LANES-1:0]        req_active = '0;
    logic [LANES*ADDR_W-1:0] req_addr = '0;
    logic                    busy;
    logic [LANES-1:0]        grant_mask;
    logic                    done;
    logic [DEG_W-1:0]        conflict_degree;

    int          n_checks = 0;
    int          n_fail = 0;
    exp_t        eq[$];
    int unsigned a[LANES];
    logic [LANES-1:0] act;
    logic [LANES-1:0] seen = '0;
    int          pass_no = 0;

    always #2.5 clk = ~clk;

    bank_conflict_arbiter dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_active(req_active),
        .req_addr(req_addr), .busy(busy), .grant_mask(grant_mask), .done(done),
        .conflict_degree(conflict_degree)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] actual, input logic [63:0] expected);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, actual, expected);
        end
    endtask

    function automatic int unsigned word_of(int unsigned addr);
        return addr >> 2;
    endfunction

    // driver-side model: pushes expected passes for the current a[]/act
    task automatic push_expected();
        logic [LANES-1:0] pend, g;
        int deg, cnt, lead;
        bit dup;
        exp_t e;
        deg = 0;
        for (int b = 0; b < 32; b++) begin
            cnt = 0;
            for (int i = 0; i < LANES; i++) begin
                if (act[i] && word_of(a[i]) % 32 == b) begin
                    dup = 0;
                    for (int j = 0; j < i; j++)
                        if (act[j] && word_of(a[j]) == word_of(a[i])) dup = 1;
                    if (!dup) cnt++;
                end
            end
            if (cnt > deg) deg = cnt;
        end
        pend = act;
        if (pend == '0) begin
            e.mask = '0; e.last = 1; e.deg = 0; e.act = act;
            eq.push_back(e);
        end
        while (pend != '0) begin
            g = '0;
            for (int b = 0; b < 32; b++) begin
                lead = -1;
                for (int i = 0; i < LANES; i++)
                    if (lead < 0 && pend[i] && word_of(a[i]) % 32 == b) lead = i;
                if (lead >= 0)
                    for (int i = 0; i < LANES; i++)
                        if (pend[i] && word_of(a[i]) == word_of(a[lead])) g[i] = 1'b1;
            end
            pend = pend & ~g;
            e.mask = g; e.last = (pend == '0); e.deg = deg; e.act = act;
            eq.push_back(e);
        end
    endtask

    task automatic drive_req(input bit try_refuse);
        push_expected();
        @(negedge clk);
        while (busy) @(negedge clk);
        for (int i = 0; i < LANES; i++) req_addr[i*ADDR_W +: ADDR_W] = a[i][ADDR_W-1:0];
        req_active = act;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(busy === 1'b1, "R8 busy after accept", busy, 1);
        if (try_refuse) begin
            // R9: a different request while busy must be ignored
            req_active = '1;
            for (int i = 0; i < LANES; i++) req_addr[i*ADDR_W +: ADDR_W] = 16'(i * 128);
            req_valid = 1'b1;
            @(negedge clk);
            check(busy === 1'b1, "R9 still busy during refused request", busy, 1);
            req_valid = 1'b0;
        end
        while (busy || eq.size() != 0) @(negedge clk);
    endtask

    // monitor: compares each pass against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && busy) begin
            if (eq.size() == 0) begin
                check(0, "R8 unexpected pass", grant_mask, 0);
            end else begin
                exp_t e;
                e = eq.pop_front();
                pass_no++;
                check(grant_mask === e.mask, "R5 R6 grant mask", grant_mask, e.mask);
                check(done === e.last, "R10 done flag", done, e.last);
                check(conflict_degree === DEG_W'(e.deg), "R3 conflict degree", conflict_degree, e.deg);
                seen = seen | grant_mask;
                if (e.last) begin
                    check(seen === e.act, "R7 all active lanes granted", seen, e.act);
                    check(pass_no == ((e.deg == 0) ? 1 : e.deg), "R4 pass count", pass_no, e.deg);
                    seen = '0;
                    pass_no = 0;
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] lcg;
        repeat (3) @(negedge clk);
        // R11 reset state
        check(busy === 1'b0, "R11 busy", busy, 0);
        check(done === 1'b0, "R11 done", done, 0);
        check(grant_mask === '0, "R11 grant", grant_mask, 0);
        check(conflict_degree === '0, "R11 degree", conflict_degree, 0);
        rst_n = 1'b1;
        @(negedge clk);

        act = '1;
        for (int i = 0; i < LANES; i++) a[i] = 4 * i;        // R2 stride 1
        drive_req(0);
        for (int i = 0; i < LANES; i++) a[i] = 8 * i;        // R3 stride 2 -> 2-way
        drive_req(0);
        for (int i = 0; i < LANES; i++) a[i] = 12 * i;       // R2 stride 3
        drive_req(0);
        for (int i = 0; i < LANES; i++) a[i] = 32'h40;       // R2 full broadcast
        drive_req(0);
        for (int i = 0; i < LANES; i++) a[i] = i;            // R1 bytes within words
        drive_req(0);
        for (int i = 0; i < LANES; i++) a[i] = 128 * i;      // R3 32-way
        drive_req(0);
        for (int i = 0; i < LANES; i++) a[i] = 16 * i;       // R9 4-way with refused request
        drive_req(1);
        act = '0;                                            // R4 no active lanes
        drive_req(0);
        act = 32'hAAAA_5555;                                 // R6 inactive lanes, R1 same bank other row
        for (int i = 0; i < LANES; i++) a[i] = (i % 4) * 128 + (i % 3) * 4 + (i % 2);
        drive_req(0);
        lcg = 32'h1234_5678;
        for (int r = 0; r < 6; r++) begin                    // R5 mixed patterns
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            act = lcg;
            for (int i = 0; i < LANES; i++) begin
                lcg = lcg * 32'd1664525 + 32'd1013904223;
                a[i] = lcg[23:8] & 32'h0000_03FF;
            end
            drive_req(0);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule